// File: doc/BRIEF.md
# Load-Link / Store-Conditional Reservation Unit

This block sits beside the memory stage of a 32-bit processor and keeps the single reservation that makes load-linked / store-conditional sequences atomic. Every cycle the pipeline may present one memory operation, made up of the instruction word, an effective address and store data. A small decoder picks out the two atomic opcodes from the instruction's major opcode field. Ordinary stores are flagged by the pipeline on a separate strobe.

A load-linked word records its address and raises the reservation flag. A store-conditional succeeds only while that flag is up and its address matches the recorded one. Only on success does it write to a simple synchronous memory port. Its outcome goes out on a strobe, so the pipeline can copy it into the status register's condition flag and software can branch on it. Any store-conditional drops the reservation, whether or not it succeeds. An ordinary store of any width that lands in the reserved word also drops it, and that store still goes to memory.

The success flag, the write strobe, the byte enables and the alignment error are combinational, in the same cycle as the operation. Changes to the reservation take effect at the next clock edge.

Top module: `llsc_resv_unit`

## Requirements
- R1: The major opcode is taken from instruction bits 31:26. Opcode 0x1B is load-linked word and opcode 0x33 is store-conditional word. A valid operation with any other opcode and no ordinary-store strobe produces no write, no read strobe, no flag write and no change to the reservation.
- R2: After reset the reservation flag is 0 and the reserved address is 0, so a store-conditional issued before any load-linked reports failure and does not write.
- R3: An aligned load-linked asserts the read strobe in its own cycle. From the next edge the flag is 1 and the reserved address equals its effective address. This replaces any reservation already held.
- R4: An aligned store-conditional raises the condition-flag write strobe in its own cycle. Its success output is the reservation flag ANDed with equality of its address and the reserved address. On success it writes the full store data with all four byte enables, and on failure it writes nothing.
- R5: After every aligned store-conditional the reservation flag is 0 from the next edge, both on success and on failure.
- R6: An ordinary store always writes in its own cycle. Width code 0 is a byte: enable bit equal to address bits 1:0, data byte copied to all lanes. Width code 1 is a halfword: enables 0x3, or 0xC when address bit 1 is set, halfword copied to both halves. Width code 2 is a word: enables 0xF. The memory address is the effective address with bits 1:0 cleared.
- R7: An ordinary store whose address, with bits 1:0 cleared, equals the reserved address clears the reservation flag from the next edge. A store to any other word leaves the reservation intact.
- R8: A load-linked or store-conditional whose address bits 1:0 are not zero raises the alignment error. It performs no write, no read strobe and no flag write, and it leaves the reservation flag and address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memValid | input | 1 | A memory operation is presented this cycle |
| instrWord | input | 32 | Instruction word; bits 31:26 are decoded |
| plainStore | input | 1 | The operation is an ordinary (non-atomic) store |
| storeWidth | input | 2 | Ordinary store width: 0 byte, 1 halfword, 2 word |
| effAddr | input | ADDR_W | Effective address (base plus sign-extended offset) |
| storeData | input | DATA_W | Source register value for stores |
| memWe | output | 1 | Memory write enable |
| memByteEn | output | DATA_W/8 | Byte lane enables for the write |
| memAddr | output | ADDR_W | Word-aligned memory address |
| memWdata | output | DATA_W | Write data, lanes replicated by width |
| llRead | output | 1 | Load-linked word read strobe |
| scSuccess | output | 1 | Store-conditional outcome |
| condFlagWe | output | 1 | Write scSuccess into the condition flag |
| alignErr | output | 1 | Misaligned atomic access |
| resvValid | output | 1 | Reservation flag |
| resvAddr | output | ADDR_W | Reserved address |

## Verification
The assertions assume that the pipeline never raises plainStore together with an atomic opcode, so each cycle carries at most one kind of operation. The stimulus keeps to this: it builds every operation from a single kind, clearing plainStore for atomic and unrelated opcodes. Random traffic draws its addresses from a four-word window and sometimes misaligns them. This makes reservation hits, replacements, clears by ordinary stores and misaligned atomics all occur often.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  localparam logic [5:0] OP_LOAD_LINK  = 6'h1B;
  localparam logic [5:0] OP_STORE_COND = 6'h33;
  localparam int OPC_HI = 31;
  localparam int OPC_LO = 26;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } storeSize_e;

  typedef struct packed {
    logic setResv;
    logic clearResv;
    logic scWrite;
    logic plainWrite;
  } resvCtrl_t;
endpackage

// File: rtl/llsc_decode.sv
module llsc_decode
  import llsc_pkg::*;
(
  input  logic        opValid,
  input  logic [31:0] instr,
  input  logic        plainStoreIn,
  output logic        isLoadLink,
  output logic        isStoreCond,
  output logic        isPlainStore
);
  logic [5:0] majorOp;

  always_comb begin
    majorOp      = instr[OPC_HI:OPC_LO];
    isLoadLink   = opValid && (majorOp == OP_LOAD_LINK);
    isStoreCond  = opValid && (majorOp == OP_STORE_COND);
    isPlainStore = opValid && plainStoreIn && !isLoadLink && !isStoreCond;
  end
endmodule

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
  import llsc_pkg::*;
(
  input  logic      isLoadLink,
  input  logic      isStoreCond,
  input  logic      isPlainStore,
  input  logic      misaligned,
  input  logic      hitExact,
  input  logic      hitWord,
  output resvCtrl_t ctrl,
  output logic      scOk,
  output logic      flagWe,
  output logic      alignFault,
  output logic      readStrobe
);
  logic llGo;
  logic scGo;

  always_comb begin
    alignFault = (isLoadLink || isStoreCond) && misaligned;
    llGo       = isLoadLink && !misaligned;
    scGo       = isStoreCond && !misaligned;
    scOk       = scGo && hitExact;
    flagWe     = scGo;
    readStrobe = llGo;

    ctrl.setResv    = llGo;
    ctrl.clearResv  = scGo || (isPlainStore && hitWord);
    ctrl.scWrite    = scOk;
    ctrl.plainWrite = isPlainStore;
  end
endmodule

// File: rtl/llsc_datapath.sv
module llsc_datapath
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  resvCtrl_t           ctrl,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [1:0]          widthIn,
  output logic                misaligned,
  output logic                hitExact,
  output logic                hitWord,
  output logic                resvFlag,
  output logic [ADDR_W-1:0]   resvWord,
  output logic                wrEn,
  output logic [DATA_W/8-1:0] wrLanes,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [DATA_W-1:0]   wrData
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int HALVES = LANES / 2;

  logic [ADDR_W-1:0]  alignedAddr;
  logic [LANES-1:0]   byteLane;
  logic [LANES-1:0]   halfLane;
  logic [DATA_W-1:0]  byteRep;
  logic [DATA_W-1:0]  halfRep;
  storeSize_e         sizeSel;

  always_comb begin
    alignedAddr = {addrIn[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    misaligned  = addrIn[OFF_W-1:0] != '0;
    hitExact    = resvFlag && (addrIn == resvWord);
    hitWord     = resvFlag && (alignedAddr == resvWord);
    sizeSel     = storeSize_e'(widthIn);
  end

  always_comb begin
    byteLane = '0;
    byteLane[addrIn[OFF_W-1:0]] = 1'b1;
    halfLane = '0;
    halfLane[{addrIn[OFF_W-1:1], 1'b0}]      = 1'b1;
    halfLane[{addrIn[OFF_W-1:1], 1'b0} + 1]  = 1'b1;
  end

  for (genvar g = 0; g < LANES; g++) begin : gByteRep
    assign byteRep[g*8 +: 8] = dataIn[7:0];
  end
  for (genvar g = 0; g < HALVES; g++) begin : gHalfRep
    assign halfRep[g*16 +: 16] = dataIn[15:0];
  end

  always_comb begin
    wrEn    = ctrl.scWrite || ctrl.plainWrite;
    wrAddr  = alignedAddr;
    wrLanes = '0;
    wrData  = '0;
    if (ctrl.scWrite) begin
      wrLanes = '1;
      wrData  = dataIn;
    end else if (ctrl.plainWrite) begin
      case (sizeSel)
        SZ_BYTE: begin wrLanes = byteLane; wrData = byteRep; end
        SZ_HALF: begin wrLanes = halfLane; wrData = halfRep; end
        default: begin wrLanes = '1;       wrData = dataIn;  end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resvFlag <= 1'b0;
      resvWord <= '0;
    end else if (ctrl.setResv) begin
      resvFlag <= 1'b1;
      resvWord <= addrIn;
    end else if (ctrl.clearResv) begin
      resvFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/llsc_resv_unit.sv
module llsc_resv_unit
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                memValid,
  input  logic [31:0]         instrWord,
  input  logic                plainStore,
  input  logic [1:0]          storeWidth,
  input  logic [ADDR_W-1:0]   effAddr,
  input  logic [DATA_W-1:0]   storeData,
  output logic                memWe,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic                llRead,
  output logic                scSuccess,
  output logic                condFlagWe,
  output logic                alignErr,
  output logic                resvValid,
  output logic [ADDR_W-1:0]   resvAddr
);
  logic      isLl;
  logic      isSc;
  logic      isSt;
  logic      misaligned;
  logic      hitExact;
  logic      hitWord;
  resvCtrl_t ctrl;

  llsc_decode uDecode (
    .opValid      (memValid),
    .instr        (instrWord),
    .plainStoreIn (plainStore),
    .isLoadLink   (isLl),
    .isStoreCond  (isSc),
    .isPlainStore (isSt)
  );

  llsc_ctrl uCtrl (
    .isLoadLink   (isLl),
    .isStoreCond  (isSc),
    .isPlainStore (isSt),
    .misaligned   (misaligned),
    .hitExact     (hitExact),
    .hitWord      (hitWord),
    .ctrl         (ctrl),
    .scOk         (scSuccess),
    .flagWe       (condFlagWe),
    .alignFault   (alignErr),
    .readStrobe   (llRead)
  );

  llsc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .addrIn     (effAddr),
    .dataIn     (storeData),
    .widthIn    (storeWidth),
    .misaligned (misaligned),
    .hitExact   (hitExact),
    .hitWord    (hitWord),
    .resvFlag   (resvValid),
    .resvWord   (resvAddr),
    .wrEn       (memWe),
    .wrLanes    (memByteEn),
    .wrAddr     (memAddr),
    .wrData     (memWdata)
  );
endmodule

// File: rtl/llsc_checker.sv
module llsc_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                memValid,
  input logic [31:0]         instrWord,
  input logic                plainStore,
  input logic [ADDR_W-1:0]   effAddr,
  input logic                memWe,
  input logic [DATA_W/8-1:0] memByteEn,
  input logic                llRead,
  input logic                scSuccess,
  input logic                condFlagWe,
  input logic                alignErr,
  input logic                resvValid,
  input logic [ADDR_W-1:0]   resvAddr
);
  logic llIn, scIn, stIn, lowBits;
  assign llIn    = memValid && instrWord[31:26] == 6'h1B;
  assign scIn    = memValid && instrWord[31:26] == 6'h33;
  assign stIn    = memValid && plainStore && !llIn && !scIn;
  assign lowBits = effAddr[1:0] != 2'b00;

  p_ll_records_r3: assert property (@(posedge clk) disable iff (!rstN)
    (llIn && !lowBits) |=> (resvValid && resvAddr == $past(effAddr)));

  p_sc_write_needs_match_r4: assert property (@(posedge clk) disable iff (!rstN)
    (scIn && memWe) |-> (resvValid && effAddr == resvAddr && memByteEn == '1));

  p_sc_drops_resv_r5: assert property (@(posedge clk) disable iff (!rstN)
    (scIn && !lowBits) |=> !resvValid);

  p_store_writes_r6: assert property (@(posedge clk) disable iff (!rstN)
    stIn |-> memWe);

  p_store_hit_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stIn && resvValid && effAddr[ADDR_W-1:2] == resvAddr[ADDR_W-1:2]) |=> !resvValid);

  p_misaligned_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> (!memWe && !condFlagWe && !llRead && !scSuccess));

  p_misaligned_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |=> ($stable(resvValid) && $stable(resvAddr)));

  p_other_op_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!llIn && !scIn && !stIn) |-> (!memWe && !llRead && !condFlagWe && !alignErr));
endmodule

bind llsc_resv_unit llsc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChecker (
  .clk        (clk),
  .rstN       (rstN),
  .memValid   (memValid),
  .instrWord  (instrWord),
  .plainStore (plainStore),
  .effAddr    (effAddr),
  .memWe      (memWe),
  .memByteEn  (memByteEn),
  .llRead     (llRead),
  .scSuccess  (scSuccess),
  .condFlagWe (condFlagWe),
  .alignErr   (alignErr),
  .resvValid  (resvValid),
  .resvAddr   (resvAddr)
);

// File: tb/llsc_resv_unit_test.sv
`timescale 1ns/1ps
module llsc_resv_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        plainStore = 1'b0;
  logic [1:0]  storeWidth = '0;
  logic [31:0] effAddr = '0;
  logic [31:0] storeData = '0;
  logic        memWe;
  logic [3:0]  memByteEn;
  logic [31:0] memAddr;
  logic [31:0] memWdata;
  logic        llRead, scSuccess, condFlagWe, alignErr, resvValid;
  logic [31:0] resvAddr;

  int checks = 0;
  int fails = 0;
  bit mV = 0;
  logic [31:0] mA = '0;

  localparam logic [5:0] LL = 6'h1B, SC = 6'h33, ST = 6'h35, ALU = 6'h38;

  always #2.5 clk = ~clk;

  llsc_resv_unit uut (
    .clk(clk), .rstN(rstN), .memValid(memValid), .instrWord(instrWord),
    .plainStore(plainStore), .storeWidth(storeWidth), .effAddr(effAddr),
    .storeData(storeData), .memWe(memWe), .memByteEn(memByteEn),
    .memAddr(memAddr), .memWdata(memWdata), .llRead(llRead),
    .scSuccess(scSuccess), .condFlagWe(condFlagWe), .alignErr(alignErr),
    .resvValid(resvValid), .resvAddr(resvAddr)
  );

  task automatic finishUp();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finishUp();
  end

  task automatic check(input string tag, input logic [105:0] act, input logic [105:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one operation, compare against the behavioural model, then advance it.
  task automatic doOp(input string tag, input bit v, input logic [5:0] op,
                      input bit ps, input logic [1:0] w,
                      input logic [31:0] a, input logic [31:0] d);
    bit isLl, isSc, isSt, mis, nV;
    logic [31:0] nA;
    logic eWe, eLl, eSucc, eFlag, eErr;
    logic [3:0] eBe;
    logic [31:0] eWd;
    @(negedge clk);
    memValid = v; instrWord = {op, 26'h155AA33}; plainStore = ps;
    storeWidth = w; effAddr = a; storeData = d;
    #1;
    isLl = v && op == LL;
    isSc = v && op == SC;
    isSt = v && ps && !isLl && !isSc;
    mis = a[1:0] != 2'b00;
    nV = mV; nA = mA;
    eWe = 0; eLl = 0; eSucc = 0; eFlag = 0; eErr = 0; eBe = 0; eWd = 0;
    if ((isLl || isSc) && mis) eErr = 1;
    else if (isLl) begin eLl = 1; nV = 1; nA = a; end
    else if (isSc) begin
      eFlag = 1;
      eSucc = mV && (mA == a);
      if (eSucc) begin eWe = 1; eBe = 4'hF; eWd = d; end
      nV = 0;
    end else if (isSt) begin
      eWe = 1;
      case (w)
        2'd0: begin eBe = 4'b0001 << a[1:0]; eWd = {4{d[7:0]}}; end
        2'd1: begin eBe = a[1] ? 4'hC : 4'h3; eWd = {2{d[15:0]}}; end
        default: begin eBe = 4'hF; eWd = d; end
      endcase
      if (mV && {a[31:2], 2'b00} == mA) nV = 0;
    end
    check(tag,
      {memWe, memByteEn, memAddr, memWdata, llRead, scSuccess, condFlagWe, alignErr, resvValid, resvAddr},
      {eWe, eBe, {a[31:2], 2'b00}, eWd, eLl, eSucc, eFlag, eErr, mV, mA});
    mV = nV; mA = nA;
  endtask

  task automatic idle(input string tag);
    doOp(tag, 0, ALU, 0, 2'd0, 32'h0, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (resvValid !== 1'b0 || resvAddr !== 32'h0) begin
      fails++;
      $display("FAIL R2 reset: actual %b/%h expected 0/00000000", resvValid, resvAddr);
    end
    rstN = 1'b1;
    doOp("R2 sc before ll fails", 1, SC, 0, 2'd2, 32'h0000_0000, 32'hDEAD_BEEF);
    doOp("R2 sc fails elsewhere", 1, SC, 0, 2'd2, 32'h0000_0100, 32'h1111_2222);
    doOp("R3 ll sets", 1, LL, 0, 2'd0, 32'h0000_0100, 32'h0);
    doOp("R4 sc success", 1, SC, 0, 2'd2, 32'h0000_0100, 32'hCAFE_F00D);
    doOp("R5 cleared after success", 1, SC, 0, 2'd2, 32'h0000_0100, 32'h5);
    doOp("R3 ll", 1, LL, 0, 2'd0, 32'h0000_0200, 32'h0);
    doOp("R4 sc wrong addr", 1, SC, 0, 2'd2, 32'h0000_0204, 32'h7);
    doOp("R5 cleared after failure", 1, SC, 0, 2'd2, 32'h0000_0200, 32'h8);
    doOp("R3 ll first", 1, LL, 0, 2'd0, 32'h0000_0300, 32'h0);
    doOp("R3 ll replaces", 1, LL, 0, 2'd0, 32'h0000_0400, 32'h0);
    doOp("R3 old addr fails", 1, SC, 0, 2'd2, 32'h0000_0300, 32'h9);
    doOp("R3 ll", 1, LL, 0, 2'd0, 32'h0000_0500, 32'h0);
    doOp("R7 byte store hits word", 1, ST, 1, 2'd0, 32'h0000_0503, 32'h0000_00A5);
    doOp("R7 sc after hit fails", 1, SC, 0, 2'd2, 32'h0000_0500, 32'h1);
    doOp("R3 ll", 1, LL, 0, 2'd0, 32'h0000_0600, 32'h0);
    doOp("R6 half store upper", 1, ST, 1, 2'd1, 32'h0000_0702, 32'h0000_BEEF);
    doOp("R6 half store lower", 1, ST, 1, 2'd1, 32'h0000_0704, 32'h0000_1234);
    doOp("R6 word store", 1, ST, 1, 2'd2, 32'h0000_0708, 32'h89AB_CDEF);
    doOp("R7 reservation kept", 1, SC, 0, 2'd2, 32'h0000_0600, 32'h2);
    doOp("R3 ll", 1, LL, 0, 2'd0, 32'h0000_0900, 32'h0);
    doOp("R8 misaligned ll", 1, LL, 0, 2'd0, 32'h0000_0801, 32'h0);
    doOp("R8 misaligned sc", 1, SC, 0, 2'd2, 32'h0000_0902, 32'h3);
    doOp("R1 other opcode ignored", 1, ALU, 0, 2'd2, 32'h0000_0900, 32'h4);
    doOp("R1 invalid cycle ignored", 0, SC, 0, 2'd2, 32'h0000_0900, 32'h4);
    doOp("R7 halfword store same word", 1, ST, 1, 2'd1, 32'h0000_0902, 32'h4);
    idle("R7 state after clear");
    for (int i = 0; i < 400; i++) begin
      int k;
      logic [5:0] op;
      logic [31:0] a;
      k = $urandom_range(0, 3);
      a = 32'h0000_1000 + 32'($urandom_range(0, 3) * 4);
      if ($urandom_range(0, 7) == 0) a[1:0] = 2'($urandom_range(1, 3));
      op = (k == 0) ? LL : (k == 1) ? SC : (k == 2) ? ST : ALU;
      doOp("R4 random traffic", 1, op, k == 2, 2'($urandom_range(0, 2)), a, $urandom);
    end
    idle("R5 final state");
    finishUp();
  end
endmodule